// File: doc/BRIEF.md
# Bouncing ball position updater

This block tracks a ball moving along one axis between two fixed walls, one at position 0 and one at position 100. It holds a signed position and a signed velocity in registers. On every clock edge it adds the velocity to the position. If the sum passes a wall, the ball is folded back inside by the distance it overshot, and the velocity reverses. The result behaves like a real elastic rebound: the ball never ends a step outside the walls, and it does not lag a step behind a wall before turning around.

A synchronous load port writes a chosen starting position and velocity. The load takes priority over the motion update. The block is free-running: once loaded, it advances one step per cycle with no further control. Loaded positions are assumed to lie in 0..100, and loaded speeds are assumed to be at most 100.

Top module: `ball_bounce_tracker`

## Requirements
- R1: While rst_ni is low, pos_o and vel_o are both 0.
- R2: At a rising clock edge with load_i high, pos_o takes pos_init_i and vel_o takes vel_init_i. While load_i stays high, no motion step is applied.
- R3: At a rising clock edge with load_i low, let the tentative position t be pos_o + vel_o. If t lies in 0..100 inclusive, pos_o becomes t and vel_o is unchanged.
- R4: If t is greater than 100, pos_o becomes 200 - t and vel_o becomes its negation.
- R5: If t is less than 0, pos_o becomes -t and vel_o becomes its negation.
- R6: A step that lands exactly on 0 or exactly on 100 is not a bounce, so vel_o keeps its sign.
- R7: Starting from a load with a position in 0..100 and a speed of at most 100, pos_o stays within 0..100 at every cycle.
- R8: A motion step never changes the magnitude of vel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load the initial state this cycle |
| pos_init_i | input | 16 | Initial position, signed |
| vel_init_i | input | 16 | Initial velocity, signed |
| pos_o | output | 16 | Registered position, signed |
| vel_o | output | 16 | Registered velocity, signed |

## Verification
A load is visible on pos_o and vel_o one clock edge after it is sampled. Each motion step is visible one edge after the previous state. The bench drives inputs on the falling edge and checks outputs on the next falling edge, so every comparison falls exactly one register stage after its cause.

The bench sweeps every position in 0..100 against every velocity in -100..100. For each pair it checks both the loaded state and the first step. It also checks that a held load freezes motion. Finally, it follows a long free-running trajectory against an arithmetic model of the reflection.

// File: rtl/ball_pkg.sv
package ball_pkg;
  typedef enum logic [1:0] {
    BNC_NONE = 2'd0,
    BNC_LO   = 2'd1,
    BNC_HI   = 2'd2
  } bounce_e;
endpackage

// File: rtl/ball_wall_fold.sv
// Detects crossing of one wall and mirrors the tentative position about it.
module ball_wall_fold #(
  parameter int SUM_W = 17,
  parameter int WALL  = 0,
  parameter bit UPPER = 1'b0
) (
  input  logic signed [SUM_W-1:0] tent_i,
  output logic                    hit_o,
  output logic signed [SUM_W-1:0] fold_o
);
  localparam logic signed [SUM_W-1:0] WallS  = SUM_W'(WALL);
  localparam logic signed [SUM_W-1:0] TwiceS = SUM_W'(2 * WALL);

  always_comb begin
    hit_o  = UPPER ? (tent_i > WallS) : (tent_i < WallS);
    fold_o = TwiceS - tent_i;
  end
endmodule

// File: rtl/ball_step.sv
module ball_step
  import ball_pkg::*;
#(
  parameter int POS_W   = 16,
  parameter int WALL_HI = 100
) (
  input  logic signed [POS_W-1:0] pos_i,
  input  logic signed [POS_W-1:0] vel_i,
  output logic signed [POS_W-1:0] pos_nxt_o,
  output logic signed [POS_W-1:0] vel_nxt_o
);
  localparam int SumW = POS_W + 1;

  logic signed [SumW-1:0] tent;
  logic                   hit  [2];
  logic signed [SumW-1:0] fold [2];
  bounce_e                kind;

  // one extra bit keeps the sum free of overflow
  assign tent = {pos_i[POS_W-1], pos_i} + {vel_i[POS_W-1], vel_i};

  for (genvar s = 0; s < 2; s++) begin : g_wall
    ball_wall_fold #(
      .SUM_W (SumW),
      .WALL  ((s == 1) ? WALL_HI : 0),
      .UPPER (s == 1)
    ) u_fold (
      .tent_i (tent),
      .hit_o  (hit[s]),
      .fold_o (fold[s])
    );
  end

  always_comb begin
    if (hit[1])      kind = BNC_HI;
    else if (hit[0]) kind = BNC_LO;
    else             kind = BNC_NONE;
    unique case (kind)
      BNC_HI: begin
        pos_nxt_o = fold[1][POS_W-1:0];
        vel_nxt_o = -vel_i;
      end
      BNC_LO: begin
        pos_nxt_o = fold[0][POS_W-1:0];
        vel_nxt_o = -vel_i;
      end
      default: begin
        pos_nxt_o = tent[POS_W-1:0];
        vel_nxt_o = vel_i;
      end
    endcase
  end
endmodule

// File: rtl/ball_state_reg.sv
module ball_state_reg #(
  parameter int POS_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic signed [POS_W-1:0] pos_init_i,
  input  logic signed [POS_W-1:0] vel_init_i,
  input  logic signed [POS_W-1:0] pos_nxt_i,
  input  logic signed [POS_W-1:0] vel_nxt_i,
  output logic signed [POS_W-1:0] pos_q_o,
  output logic signed [POS_W-1:0] vel_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q_o <= '0;
      vel_q_o <= '0;
    end else if (load_i) begin
      pos_q_o <= pos_init_i;
      vel_q_o <= vel_init_i;
    end else begin
      pos_q_o <= pos_nxt_i;
      vel_q_o <= vel_nxt_i;
    end
  end
endmodule

// File: rtl/ball_bounce_tracker.sv
module ball_bounce_tracker #(
  parameter int POS_W   = 16,
  parameter int WALL_HI = 100
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic signed [POS_W-1:0] pos_init_i,
  input  logic signed [POS_W-1:0] vel_init_i,
  output logic signed [POS_W-1:0] pos_o,
  output logic signed [POS_W-1:0] vel_o
);
  logic signed [POS_W-1:0] pos_nxt, vel_nxt;

  ball_step #(
    .POS_W   (POS_W),
    .WALL_HI (WALL_HI)
  ) u_step (
    .pos_i     (pos_o),
    .vel_i     (vel_o),
    .pos_nxt_o (pos_nxt),
    .vel_nxt_o (vel_nxt)
  );

  ball_state_reg #(
    .POS_W (POS_W)
  ) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .pos_init_i (pos_init_i),
    .vel_init_i (vel_init_i),
    .pos_nxt_i  (pos_nxt),
    .vel_nxt_i  (vel_nxt),
    .pos_q_o    (pos_o),
    .vel_q_o    (vel_o)
  );

  a_r2_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pos_o == $past(pos_init_i) && vel_o == $past(vel_init_i)));

  a_r4_upper_fold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (int'(pos_o) + int'(vel_o) > WALL_HI)) |=>
      (int'(pos_o) == 2 * WALL_HI - int'($past(pos_o)) - int'($past(vel_o))
       && int'(vel_o) == -int'($past(vel_o))));

  a_r5_lower_fold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (int'(pos_o) + int'(vel_o) < 0)) |=>
      (int'(pos_o) == -(int'($past(pos_o)) + int'($past(vel_o)))
       && int'(vel_o) == -int'($past(vel_o))));

  a_r6_edge_keeps_vel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (int'(pos_o) + int'(vel_o) == 0 || int'(pos_o) + int'(vel_o) == WALL_HI))
      |=> (vel_o == $past(vel_o)));

  a_r8_speed_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (vel_o == $past(vel_o) || int'(vel_o) == -int'($past(vel_o))));

  a_r7_pos_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && pos_o >= 0 && pos_o <= WALL_HI && int'(vel_o) <= WALL_HI
     && int'(vel_o) >= -WALL_HI) |=> (pos_o >= 0 && pos_o <= WALL_HI));
endmodule

// File: tb/ball_bounce_tracker_bench.sv
module ball_bounce_tracker_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0;
  logic signed [15:0] pos_init_i = '0;
  logic signed [15:0] vel_init_i = '0;
  logic signed [15:0] pos_o, vel_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  ball_bounce_tracker u_ball_bounce_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .pos_init_i (pos_init_i),
    .vel_init_i (vel_init_i),
    .pos_o      (pos_o),
    .vel_o      (vel_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input int p, input int v, output int np, output int nv);
    int t;
    t = p + v;
    if (t > 100) begin
      np = 200 - t;
      nv = -v;
    end else if (t < 0) begin
      np = -t;
      nv = -v;
    end else begin
      np = t;
      nv = v;
    end
  endfunction

  initial begin
    int ep, ev;
    #15;
    check("R1 pos", int'(pos_o), 0);
    check("R1 vel", int'(vel_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // sweep: load then one step
    for (int p = 0; p <= 100; p++) begin
      for (int v = -100; v <= 100; v++) begin
        load_i = 1'b1;
        pos_init_i = 16'(p);
        vel_init_i = 16'(v);
        @(negedge clk_i);
        load_i = 1'b0;
        check("R2 pos", int'(pos_o), p);
        check("R2 vel", int'(vel_o), v);
        @(negedge clk_i);
        model(p, v, ep, ev);
        if (p + v > 100)    check("R4 step", int'(pos_o) * 1000 + int'(vel_o), ep * 1000 + ev);
        else if (p + v < 0) check("R5 step", int'(pos_o) * 1000 + int'(vel_o), ep * 1000 + ev);
        else if (p + v == 0 || p + v == 100)
                            check("R6 step", int'(pos_o) * 1000 + int'(vel_o), ep * 1000 + ev);
        else                check("R3 step", int'(pos_o) * 1000 + int'(vel_o), ep * 1000 + ev);
        check("R8 speed", (vel_o < 0) ? -int'(vel_o) : int'(vel_o), (v < 0) ? -v : v);
      end
    end

    // R2: held load freezes motion
    load_i = 1'b1;
    pos_init_i = 16'sd50;
    vel_init_i = 16'sd7;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check("R2 hold pos", int'(pos_o), 50);
      check("R2 hold vel", int'(vel_o), 7);
    end

    // R7: long free run against the model
    pos_init_i = 16'sd37;
    vel_init_i = 16'sd23;
    @(negedge clk_i);
    load_i = 1'b0;
    ep = 37;
    ev = 23;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk_i);
      model(ep, ev, ep, ev);
      check("R7 traj", int'(pos_o) * 1000 + int'(vel_o), ep * 1000 + ev);
      check("R7 range", (pos_o >= 0 && pos_o <= 100) ? 1 : 0, 1);
    end

    // R7: full-speed run
    load_i = 1'b1;
    pos_init_i = 16'sd1;
    vel_init_i = -16'sd100;
    @(negedge clk_i);
    load_i = 1'b0;
    ep = 1;
    ev = -100;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk_i);
      model(ep, ev, ep, ev);
      check("R7 fast", int'(pos_o) * 1000 + int'(vel_o), ep * 1000 + ev);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule